// File: doc/BRIEF.md
# Byte-Bus DAC Address Decoder

This block connects a 16-bit digital-to-analog converter that takes its word as two bytes to an 8-bit processor I/O bus. It watches the active-low I/O request and write strobes together with the bus address. For each write that lands in an eight-address window, it produces the converter's control pins: a chip select, high and low byte enables, a load strobe that moves the staged word to the output register, and a clear strobe. The byte data bus is passed through to the converter unchanged and without delay.

The window base is the `BASE_ADDR` parameter. The upper address bits are compared with it, and the three low bits select one action. Writes to offsets 0 and 1 stage a byte. Offsets 2 and 3 load the staged word. Offset 4 clears the output to unipolar zero and offset 5 clears it to bipolar zero. The clear target is carried on the low-byte enable, which must be at its level before the clear strobe rises. For that reason the decoder sets the level one cycle ahead of the clear. All pins are registered. A strobe is held for as long as the qualified write lasts and falls at the first clock edge that samples the write as ended.

Top module: `dac_bus_decoder`

## Requirements
- R1: No control pin leaves its idle state (`dacSelN`=1, all others 0) unless `busIorqN` and `busWrN` were both sampled low at the previous clock edge.
- R2: A write acts only when `busAddr[7:3]` equals `BASE_ADDR[7:3]`. Writes to any other address leave every pin idle.
- R3: Bit 0 of the address picks the byte. A qualified write to offset 0 drives `dacSelN`=0 and `loByteEn`=1. Offset 1 drives `dacSelN`=0 and `hiByteEn`=1. Exactly one byte enable is high whenever the select is low.
- R4: A qualified write to offset 2 or offset 3 drives `loadStb`=1 with `dacSelN`=1 and both byte enables low. At most one of select, load and clear is active in any cycle.
- R5: A qualified write to offset 4 holds `loByteEn`=0 and raises `clrStb` one cycle after the first strobe cycle. Offset 5 does the same with `loByteEn`=1 from the first strobe cycle.
- R6: During a clear, `loByteEn` holds the same level in the cycle before `clrStb` rises as in the cycle it rises.
- R7: Qualified writes to offsets 6 and 7 leave every pin idle.
- R8: The value on `busData` has no effect on the control pins, whatever the offset. `dacData` equals `busData` in the same cycle.
- R9: Strobes appear at the first clock edge that samples a qualified write, are held while it remains qualified, and return to idle at the first edge that samples `busWrN` or `busIorqN` high.
- R10: While `rstN` is low at a clock edge, all pins go to the idle state, even in the middle of a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busIorqN | input | 1 | I/O request, active low |
| busWrN | input | 1 | Write strobe, active low |
| busAddr | input | ADDR_W (8) | I/O address |
| busData | input | DATA_W (8) | Write data byte |
| dacSelN | output | 1 | Converter chip select, active low; its rising edge latches a byte |
| hiByteEn | output | 1 | High byte enable |
| loByteEn | output | 1 | Low byte enable; also the clear target (0 unipolar, 1 bipolar) |
| loadStb | output | 1 | Load strobe to the output register |
| clrStb | output | 1 | Clear strobe |
| dacData | output | DATA_W (8) | Data byte to the converter |

## Verification
The assertions assume that the bus holds the address steady for the whole of a qualified write. They also assume that the sampling clock sees each write for at least two edges, so that a clear has its setup cycle. The stimulus keeps to this rule. Every vector changes address, data and strobes together at a falling clock edge, holds them for two rising edges, and then returns the bus to idle for one edge before the next vector. The directed tests keep to the same rule when they stretch a write or assert reset in the middle of one.

// File: rtl/dac_bus_pkg.sv
package dac_bus_pkg;

  typedef struct packed {
    logic sel;
    logic hiEn;
    logic loEn;
    logic load;
    logic clr;
  } dacStb_t;

  typedef enum logic [2:0] {
    OFS_LO_BYTE = 3'd0,
    OFS_HI_BYTE = 3'd1,
    OFS_LOAD_A  = 3'd2,
    OFS_LOAD_B  = 3'd3,
    OFS_CLR_UNI = 3'd4,
    OFS_CLR_BIP = 3'd5,
    OFS_SPARE_A = 3'd6,
    OFS_SPARE_B = 3'd7
  } dacOfs_t;

  localparam int OFS_W = 3;

endpackage

// File: rtl/dac_bus_ctrl.sv
module dac_bus_ctrl
  import dac_bus_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              iorqN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  output dacStb_t           stb
);

  logic    inWindow;
  logic    hit;
  logic    clrHit;
  logic    clrArm;
  dacOfs_t ofs;

  assign inWindow = (addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
  assign hit      = !iorqN && !wrN && inWindow;
  assign ofs      = dacOfs_t'(addr[OFS_W-1:0]);
  assign clrHit   = hit && ((ofs == OFS_CLR_UNI) || (ofs == OFS_CLR_BIP));

  // The first cycle of a clear only sets the target level.
  always_ff @(posedge clk) begin
    if (!rstN) clrArm <= 1'b0;
    else       clrArm <= clrHit;
  end

  always_comb begin
    stb = '0;
    if (hit) begin
      unique case (ofs)
        OFS_LO_BYTE: begin stb.sel = 1'b1; stb.loEn = 1'b1; end
        OFS_HI_BYTE: begin stb.sel = 1'b1; stb.hiEn = 1'b1; end
        OFS_LOAD_A,
        OFS_LOAD_B:  stb.load = 1'b1;
        OFS_CLR_UNI: stb.clr  = clrArm;
        OFS_CLR_BIP: begin stb.loEn = 1'b1; stb.clr = clrArm; end
        default:     stb = '0;
      endcase
    end
  end

endmodule

// File: rtl/dac_bus_dpath.sv
module dac_bus_dpath
  import dac_bus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dacStb_t           stb,
  input  logic [DATA_W-1:0] busData,
  output logic              dacSelN,
  output logic              hiByteEn,
  output logic              loByteEn,
  output logic              loadStb,
  output logic              clrStb,
  output logic [DATA_W-1:0] dacData
);

  dacStb_t stbQ;

  always_ff @(posedge clk) begin
    if (!rstN) stbQ <= '0;
    else       stbQ <= stb;
  end

  assign dacSelN  = !stbQ.sel;
  assign hiByteEn = stbQ.hiEn;
  assign loByteEn = stbQ.loEn;
  assign loadStb  = stbQ.load;
  assign clrStb   = stbQ.clr;

  for (genvar i = 0; i < DATA_W; i++) begin : g_pass
    assign dacData[i] = busData[i];
  end

  AST_SEL_ONE_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    !dacSelN |-> (hiByteEn != loByteEn)); // R3

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({!dacSelN, loadStb, clrStb})); // R4

  AST_CLR_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clrStb) |-> $stable(loByteEn)); // R6

endmodule

// File: rtl/dac_bus_decoder.sv
module dac_bus_decoder
  import dac_bus_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busIorqN,
  input  logic              busWrN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  output logic              dacSelN,
  output logic              hiByteEn,
  output logic              loByteEn,
  output logic              loadStb,
  output logic              clrStb,
  output logic [DATA_W-1:0] dacData
);

  dacStb_t stb;

  dac_bus_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .iorqN (busIorqN),
    .wrN   (busWrN),
    .addr  (busAddr),
    .stb   (stb)
  );

  dac_bus_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busData  (busData),
    .dacSelN  (dacSelN),
    .hiByteEn (hiByteEn),
    .loByteEn (loByteEn),
    .loadStb  (loadStb),
    .clrStb   (clrStb),
    .dacData  (dacData)
  );

  AST_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    (!dacSelN || hiByteEn || loByteEn || loadStb || clrStb)
      |-> $past(!busIorqN && !busWrN)); // R1

endmodule

// File: tb/sim_dac_bus_decoder.sv
module sim_dac_bus_decoder;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busIorqN = 1'b1;
  logic       busWrN = 1'b1;
  logic [7:0] busAddr = '0;
  logic [7:0] busData = '0;
  logic       dacSelN, hiByteEn, loByteEn, loadStb, clrStb;
  logic [7:0] dacData;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dac_bus_decoder #(.ADDR_W(8), .DATA_W(8), .BASE_ADDR(8'h40)) u0 (
    .clk(clk), .rstN(rstN), .busIorqN(busIorqN), .busWrN(busWrN),
    .busAddr(busAddr), .busData(busData),
    .dacSelN(dacSelN), .hiByteEn(hiByteEn), .loByteEn(loByteEn),
    .loadStb(loadStb), .clrStb(clrStb), .dacData(dacData)
  );

  // Pin order {dacSelN, hiByteEn, loByteEn, loadStb, clrStb}; idle = 5'b10000.
  // Vector: {addr, data, iorqN, wrN, expected after edge 1, expected after edge 2}
  localparam int NV = 14;
  localparam logic [27:0] VEC [NV] = '{
    {8'h40, 8'hA5, 1'b0, 1'b0, 5'b00100, 5'b00100}, // R3 low byte
    {8'h41, 8'h3C, 1'b0, 1'b0, 5'b01000, 5'b01000}, // R3 high byte
    {8'h42, 8'hFF, 1'b0, 1'b0, 5'b10010, 5'b10010}, // R4 load
    {8'h43, 8'h00, 1'b0, 1'b0, 5'b10010, 5'b10010}, // R4 load alias
    {8'h44, 8'h77, 1'b0, 1'b0, 5'b10000, 5'b10001}, // R5 clear unipolar
    {8'h45, 8'h11, 1'b0, 1'b0, 5'b10100, 5'b10101}, // R5 clear bipolar
    {8'h46, 8'h5A, 1'b0, 1'b0, 5'b10000, 5'b10000}, // R7
    {8'h47, 8'hC3, 1'b0, 1'b0, 5'b10000, 5'b10000}, // R7
    {8'h48, 8'hA5, 1'b0, 1'b0, 5'b10000, 5'b10000}, // R2 next window
    {8'h00, 8'hA5, 1'b0, 1'b0, 5'b10000, 5'b10000}, // R2 far address
    {8'h40, 8'hA5, 1'b1, 1'b0, 5'b10000, 5'b10000}, // R1 no I/O request
    {8'h41, 8'hA5, 1'b0, 1'b1, 5'b10000, 5'b10000}, // R1 no write
    {8'h42, 8'h00, 1'b0, 1'b0, 5'b10010, 5'b10010}, // R8 load, other data
    {8'h45, 8'hFF, 1'b0, 1'b0, 5'b10100, 5'b10101}  // R8 clear, other data
  };

  function automatic string reqOf(input int i);
    case (i)
      0, 1:    reqOf = "R3";
      2, 3:    reqOf = "R4";
      4, 5:    reqOf = "R5";
      6, 7:    reqOf = "R7";
      8, 9:    reqOf = "R2";
      10, 11:  reqOf = "R1";
      default: reqOf = "R8";
    endcase
  endfunction

  function automatic logic [4:0] pins();
    pins = {dacSelN, hiByteEn, loByteEn, loadStb, clrStb};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic busIdle();
    busIorqN = 1'b1;
    busWrN   = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10", {3'b0, pins()}, 8'b10000);
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      busAddr  = VEC[i][27:20];
      busData  = VEC[i][19:12];
      busIorqN = VEC[i][11];
      busWrN   = VEC[i][10];
      #0.5;
      check("R8", dacData, VEC[i][19:12]);
      @(posedge clk); #1;
      check(reqOf(i), {3'b0, pins()}, {3'b0, VEC[i][9:5]});
      @(posedge clk); #1;
      check(reqOf(i), {3'b0, pins()}, {3'b0, VEC[i][4:0]});
      @(negedge clk); busIdle();
      @(posedge clk); #1;
      check("R9", {3'b0, pins()}, 8'b10000);
    end

    // R9: stretched write holds, release on first edge seeing WR high
    @(negedge clk);
    busAddr = 8'h41; busData = 8'h12; busIorqN = 1'b0; busWrN = 1'b0;
    #0.5;
    check("R9", {3'b0, pins()}, 8'b10000);
    repeat (4) @(posedge clk);
    #1;
    check("R9", {3'b0, pins()}, 8'b01000);
    @(negedge clk); busWrN = 1'b1;
    #0.5;
    check("R9", {3'b0, pins()}, 8'b01000);
    @(posedge clk); #1;
    check("R9", {3'b0, pins()}, 8'b10000);
    @(negedge clk); busIdle();

    // R6: long bipolar clear keeps level, then drops together
    @(negedge clk);
    busAddr = 8'h45; busIorqN = 1'b0; busWrN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R6", {3'b0, pins()}, 8'b10101);
    @(negedge clk); busIdle();
    @(posedge clk); #1;
    check("R6", {3'b0, pins()}, 8'b10000);

    // R10: reset in the middle of a write
    @(negedge clk);
    busAddr = 8'h40; busIorqN = 1'b0; busWrN = 1'b0;
    @(posedge clk); #1;
    check("R10", {3'b0, pins()}, 8'b00100);
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); #1;
    check("R10", {3'b0, pins()}, 8'b10000);
    @(negedge clk); busIdle(); rstN = 1'b1;
    @(posedge clk); #1;
    check("R10", {3'b0, pins()}, 8'b10000);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule